// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the target side of a four-wire serial flash interface. Chip select, serial clock and serial data in are sampled in the chip's own clock domain, and the block drives serial data out with an output-enable flag. Each transaction opens with an opcode byte and may carry a 24-bit address, dummy and data bytes. The block sorts every command into one of two classes. Read-class commands stream bytes back to the host. Write-class commands change state only when chip select returns high after a whole number of bytes.

A small byte array stands in for the flash cells. A program, erase or status-write commit starts an internal timer of a parameter-set number of clocks, and the busy flag stays high until the timer runs out. While busy, the only command the block answers is a status read. Every other command is ignored, and the running cycle finishes unchanged. Serial clock idles low. Input bits are taken on its rising edges and output bits change on its falling edges. Both edges are detected in the system clock domain.

Top module: `spi_flash_front`

## Requirements
- R1: After chip select falls, serial data in is sampled on each rising serial clock edge, most significant bit first. The first 8 bits form the opcode and all later bytes follow it.
- R2: Opcode 0x03, followed by 3 address bytes, streams array bytes from that address. Bits leave most significant first and change on falling serial clock edges. The address increments after each byte and wraps at the end of the array.
- R3: Opcode 0x0B works like 0x03, except that one dummy byte follows the address before data begins.
- R4: Opcode 0x05 returns the status byte again and again. Bit 0 is busy, bit 1 is the write-enable latch, and bits 7:2 hold the protect field. It is answered even while busy.
- R5: Opcode 0x9F returns the three identification bytes, highest byte first, and then 0x00.
- R6: so_oe is low whenever chip select has been high for a cycle. Raising chip select at any bit of a read ends the read, and the next transaction behaves normally.
- R7: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcodes 0x06, 0x04, 0x02, 0xD8, 0xC7 and 0x01 take effect only if the count of rising clock edges is a non-zero multiple of 8 when chip select rises.
- R8: Opcode 0x02, with 3 address bytes and at least one data byte, ANDs each data byte into the array. Successive bytes go to successive addresses, wrapping inside a PAGE_BYTES-aligned page.
- R9: Opcode 0xD8 with 3 address bytes sets the SECTOR_BYTES-aligned sector that holds the address to 0xFF. Opcode 0xC7 sets the whole array to 0xFF.
- R10: Opcode 0x01 with one data byte copies data bits 7:2 into the protect field. Data bits 1:0 are dropped.
- R11: A program, erase or status write with the latch clear is dropped and starts no busy cycle. When committed, it holds busy high for exactly BUSY_CYCLES clocks, and the latch clears when busy falls.
- R12: A command other than 0x05 whose opcode completes while busy produces no output and has no effect.
- R13: An unknown opcode produces no output and has no effect until chip select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idles low |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |
| busy | output | 1 | Internal program, erase or status-write cycle in progress |

## Verification
On every cycle, the assertions check four things. Output-enable drops once chip select is high. A busy cycle can only start at a byte-aligned chip-select rise with the latch set. The latch can only rise from a committed write-enable. The protect field cannot change while a cycle runs. The bench's reference model compares the busy flag on every clock. Only the scenarios can show the byte-level results. These include read data, address and page wrap, AND-programming, sector and full erase, rejection of misaligned or unlatched writes, and commands dropped during busy.

// File: rtl/spi_flash_front.sv
module spi_flash_front #(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 16,
  parameter int SECTOR_BYTES = 64,
  parameter int BUSY_CYCLES  = 64,
  parameter logic [23:0] DEV_ID = 24'hA5_3C_11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic so,
  output logic so_oe,
  output logic busy
);
  localparam int MEM_AW = $clog2(MEM_BYTES);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [MEM_AW-1:0] SEC_MASK = ~MEM_AW'(SECTOR_BYTES - 1);
  localparam logic [7:0] C_READ = 8'h03, C_FAST = 8'h0B, C_RDSR = 8'h05, C_RDID = 8'h9F,
                         C_WREN = 8'h06, C_WRDI = 8'h04, C_WRSR = 8'h01, C_PP = 8'h02,
                         C_SE = 8'hD8, C_BE = 8'hC7;

  logic sck_q, cs_q, ignore, out_mode, wel;
  logic [2:0] bit_cnt;
  logic [3:0] byte_cnt;
  logic [6:0] sr;
  logic [7:0] op, tx;
  logic [5:0] prot, prot_new;
  logic [MEM_AW-1:0] addr, rd_ptr;
  logic [PAGE_W-1:0] pg_ptr;
  logic [7:0] pg_buf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pg_mask;
  logic [7:0] mem [MEM_BYTES];
  logic [BUSY_W-1:0] busy_cnt;

  wire rise    = !sck_q && sck && !cs_n;
  wire fall    = sck_q && !sck && !cs_n;
  wire cs_fall = cs_q && !cs_n;
  wire cs_rise = !cs_q && cs_n;
  wire [7:0] in_byte = {sr, si};
  wire [7:0] cur_op  = (byte_cnt == 4'd0) ? in_byte : op;
  wire [MEM_AW-1:0] pbase = addr & ~MEM_AW'(PAGE_BYTES - 1);
  assign busy = busy_cnt != '0;

  logic known, ign_n, tx_ld;
  logic [7:0] tx_n;
  logic [MEM_AW-1:0] start_a, ptr_n;

  always_comb begin
    known   = cur_op inside {C_READ, C_FAST, C_RDSR, C_RDID, C_WREN, C_WRDI, C_WRSR, C_PP, C_SE, C_BE};
    ign_n   = (byte_cnt == 4'd0) ? ((busy && in_byte != C_RDSR) || !known) : ignore;
    start_a = (byte_cnt == 4'd3) ? MEM_AW'({addr, in_byte}) : addr;
    tx_ld = 1'b0;
    tx_n  = 8'h00;
    ptr_n = rd_ptr;
    case (cur_op)
      C_RDSR: begin tx_ld = 1'b1; tx_n = {prot, wel, busy}; end
      C_RDID: begin
        tx_ld = 1'b1;
        case (byte_cnt)
          4'd0: tx_n = DEV_ID[23:16];
          4'd1: tx_n = DEV_ID[15:8];
          4'd2: tx_n = DEV_ID[7:0];
          default: tx_n = 8'h00;
        endcase
      end
      C_READ, C_FAST: begin
        if ((cur_op == C_READ && byte_cnt == 4'd3) || (cur_op == C_FAST && byte_cnt == 4'd4)) begin
          tx_ld = 1'b1; tx_n = mem[start_a]; ptr_n = start_a + MEM_AW'(1);
        end else if (out_mode) begin
          tx_ld = 1'b1; tx_n = mem[rd_ptr]; ptr_n = rd_ptr + MEM_AW'(1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; ignore <= 1'b1; out_mode <= 1'b0; wel <= 1'b0;
      bit_cnt <= '0; byte_cnt <= '0; sr <= '0; op <= '0; tx <= '0; prot <= '0; prot_new <= '0;
      addr <= '0; rd_ptr <= '0; pg_ptr <= '0; pg_mask <= '0; busy_cnt <= '0;
      so <= 1'b0; so_oe <= 1'b0;
      for (int i = 0; i < PAGE_BYTES; i++) pg_buf[i] <= 8'h00;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (busy) begin
        busy_cnt <= busy_cnt - BUSY_W'(1);
        if (busy_cnt == BUSY_W'(1)) wel <= 1'b0;
      end
      if (cs_n) begin so_oe <= 1'b0; out_mode <= 1'b0; end
      if (cs_fall) begin
        bit_cnt <= '0; byte_cnt <= '0; ignore <= 1'b0; out_mode <= 1'b0; pg_mask <= '0;
      end
      if (rise) begin
        sr <= in_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (byte_cnt != 4'd15) byte_cnt <= byte_cnt + 4'd1;
          if (byte_cnt == 4'd0) begin op <= in_byte; ignore <= ign_n; end
          if (byte_cnt >= 4'd1 && byte_cnt <= 4'd3) addr <= MEM_AW'({addr, in_byte});
          if (byte_cnt == 4'd3) pg_ptr <= in_byte[PAGE_W-1:0];
          if (byte_cnt == 4'd1) prot_new <= in_byte[7:2];
          if (!ign_n && tx_ld) begin tx <= tx_n; rd_ptr <= ptr_n; out_mode <= 1'b1; end
          if (!ign_n && op == C_PP && byte_cnt >= 4'd4) begin
            pg_buf[pg_ptr]  <= in_byte;
            pg_mask[pg_ptr] <= 1'b1;
            pg_ptr <= pg_ptr + PAGE_W'(1);
          end
        end
      end
      if (fall && out_mode) begin
        so <= tx[7]; tx <= {tx[6:0], 1'b0}; so_oe <= 1'b1;
      end
      if (cs_rise && !ignore && byte_cnt != 4'd0 && bit_cnt == 3'd0) begin
        case (op)
          C_WREN: wel <= 1'b1;
          C_WRDI: wel <= 1'b0;
          C_PP: if (wel && byte_cnt >= 4'd5) begin
            for (int i = 0; i < PAGE_BYTES; i++)
              if (pg_mask[i]) mem[pbase | MEM_AW'(i)] <= mem[pbase | MEM_AW'(i)] & pg_buf[i];
            busy_cnt <= BUSY_W'(BUSY_CYCLES);
          end
          C_SE: if (wel && byte_cnt >= 4'd4) begin
            for (int i = 0; i < MEM_BYTES; i++)
              if ((MEM_AW'(i) & SEC_MASK) == (addr & SEC_MASK)) mem[i] <= 8'hFF;
            busy_cnt <= BUSY_W'(BUSY_CYCLES);
          end
          C_BE: if (wel) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
            busy_cnt <= BUSY_W'(BUSY_CYCLES);
          end
          C_WRSR: if (wel && byte_cnt >= 4'd2) begin
            prot <= prot_new;
            busy_cnt <= BUSY_W'(BUSY_CYCLES);
          end
          default: ;
        endcase
      end
    end
  end

  // R6: output released once chip select is high
  a_r6_oe_released: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> !so_oe);
  // R7: a busy cycle starts only at a byte-aligned chip-select rise
  a_r7_commit_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_n && bit_cnt == 3'd0));
  // R11: a busy cycle needs the write-enable latch
  a_r11_commit_needs_wel: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(wel));
  // R7: the latch rises only through a write-enable command
  a_r7_wel_from_wren: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(op == C_WREN && cs_n));
  // R12: the protect field is frozen while a cycle runs
  a_r12_prot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(prot));
endmodule

// File: tb/test_spi_flash_front.sv
module test_spi_flash_front;
  localparam int MEM = 256;
  localparam int BUSY_N = 1000;
  localparam logic [23:0] ID = 24'hA5_3C_11;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe, busy;
  always #5 clk = ~clk;

  spi_flash_front #(.MEM_BYTES(MEM), .PAGE_BYTES(16), .SECTOR_BYTES(64),
                    .BUSY_CYCLES(BUSY_N), .DEV_ID(ID))
    i_spi_flash_front (.clk, .rst_n, .sck, .cs_n, .si, .so, .so_oe, .busy);

  int checks = 0, fails = 0, cs_hi = 0;
  bit done = 0;
  logic [7:0] m_mem [MEM];
  bit m_wel = 0, m_start = 0;
  logic [5:0] m_prot = '0;
  int m_busy = 0;
  logic [7:0] rx_q [$];
  bit oe_ok, oe_seen;

  always @(posedge clk) begin
    if (m_start) begin m_busy = BUSY_N; m_start = 0; end
    else if (m_busy > 0) begin m_busy--; if (m_busy == 0) m_wel = 0; end
  end

  always @(negedge clk) if (rst_n && !done) begin
    cs_hi = cs_n ? cs_hi + 1 : 0;
    checks++;
    if (busy !== (m_busy != 0) || (cs_hi >= 2 && so_oe !== 1'b0)) begin
      fails++;
      $display("FAIL R11/R6 per-clock: actual busy=%b oe=%b expected busy=%b oe=0", busy, so_oe, m_busy != 0);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit known(logic [7:0] o);
    return o inside {8'h03, 8'h0B, 8'h05, 8'h9F, 8'h06, 8'h04, 8'h01, 8'h02, 8'hD8, 8'hC7};
  endfunction

  task automatic shift_bit(input logic b, output logic ob, output logic oe);
    @(negedge clk) si = b;
    repeat (2) @(negedge clk);
    ob = so; oe = so_oe;
    sck = 1'b1;
    repeat (3) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic commit(logic [7:0] b [$], int nbytes);
    logic [7:0] a;
    case (b[0])
      8'h06: m_wel = 1;
      8'h04: m_wel = 0;
      8'h02: if (m_wel && nbytes >= 5) begin
        a = b[3];
        for (int k = 4; k < b.size(); k++) begin
          int idx = (a & 8'hF0) | ((a + k - 4) & 8'h0F);
          m_mem[idx] = m_mem[idx] & b[k];
        end
        m_start = 1;
      end
      8'hD8: if (m_wel && nbytes >= 4) begin
        a = b[3];
        for (int k = 0; k < 64; k++) m_mem[(a & 8'hC0) + k] = 8'hFF;
        m_start = 1;
      end
      8'hC7: if (m_wel) begin
        for (int k = 0; k < MEM; k++) m_mem[k] = 8'hFF;
        m_start = 1;
      end
      8'h01: if (m_wel && nbytes >= 2) begin m_prot = b[1][7:2]; m_start = 1; end
      default: ;
    endcase
  endtask

  task automatic txn(logic [7:0] b [$], int rd_n, int tail);
    logic ob, oe;
    logic [7:0] v;
    bit ign = 1;
    int nbits;
    rx_q.delete(); oe_ok = 1; oe_seen = 0;
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    foreach (b[j]) begin
      for (int i = 7; i >= 0; i--) shift_bit(b[j][i], ob, oe);
      if (j == 0) ign = (m_busy != 0 && b[0] != 8'h05) || !known(b[0]);
    end
    for (int k = 0; k < rd_n; k++) begin
      for (int i = 7; i >= 0; i--) begin
        shift_bit(1'b0, ob, oe);
        v[i] = ob; oe_ok &= oe; oe_seen |= oe;
      end
      rx_q.push_back(v);
    end
    for (int t = 0; t < tail; t++) begin shift_bit(1'b0, ob, oe); oe_seen |= oe; end
    nbits = 8 * (b.size() + rd_n) + tail;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    if (!ign && b.size() > 0 && nbits % 8 == 0) commit(b, nbits / 8);
    repeat (3) @(negedge clk);
  endtask

  task automatic status_chk(string req);
    logic [7:0] e;
    e = {m_prot, m_wel, m_busy != 0};
    txn('{8'h05}, 2, 0);
    chk({req, " status byte 0"}, rx_q[0], e);
    chk({req, " status byte 1"}, rx_q[1], e);
  endtask

  task automatic read_chk(string req, bit fast, logic [7:0] a, int n);
    logic [7:0] e [$];
    for (int k = 0; k < n; k++) e.push_back(m_mem[(a + k) % MEM]);
    if (fast) txn('{8'h0B, 8'h00, 8'h00, a, 8'h00}, n, 0);
    else txn('{8'h03, 8'h00, 8'h00, a}, n, 0);
    chk({req, " output enable"}, oe_ok, 1);
    for (int k = 0; k < n; k++) chk({req, " read data"}, rx_q[k], e[k]);
  endtask

  task automatic wait_idle();
    while (m_busy != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < MEM; k++) m_mem[k] = 8'hFF;
    repeat (4) @(negedge clk);
    chk("R6 reset oe", so_oe, 0);
    chk("R11 reset busy", busy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    status_chk("R4 reset");
    txn('{8'h9F}, 4, 0);                                   // R5
    chk("R5 id0", rx_q[0], ID[23:16]); chk("R5 id1", rx_q[1], ID[15:8]);
    chk("R5 id2", rx_q[2], ID[7:0]);   chk("R5 tail", rx_q[3], 8'h00);
    read_chk("R2 erased", 0, 8'h10, 2);
    txn('{8'h06}, 0, 0); status_chk("R7 wren");            // R1 opcode capture
    txn('{8'h04}, 0, 0); status_chk("R7 wrdi");
    txn('{8'h06}, 0, 1); status_chk("R7 nine bits");
    txn('{}, 0, 7);      status_chk("R7 seven bits");
    txn('{8'h02, 8'h00, 8'h00, 8'h20, 8'h00}, 0, 0);        // R11 no latch
    chk("R11 no busy without latch", busy, 0);
    txn('{8'h06}, 0, 0);
    txn('{8'h02, 8'h00, 8'h00, 8'h1E, 8'h11, 8'h22, 8'h33, 8'h44}, 0, 0);
    chk("R11 busy after program", busy, 1);
    status_chk("R4 during busy");
    txn('{8'h03, 8'h00, 8'h00, 8'h1E}, 2, 0);
    chk("R12 read ignored while busy", oe_seen, 0);
    txn('{8'hD8, 8'h00, 8'h00, 8'h00}, 0, 0);               // R12 erase ignored
    wait_idle();
    status_chk("R11 latch cleared");
    read_chk("R8 page wrap", 0, 8'h1E, 2);
    read_chk("R2 increment", 0, 8'h0F, 3);
    txn('{8'h06}, 0, 0);
    txn('{8'h02, 8'h00, 8'h00, 8'h10, 8'hF0}, 0, 0); wait_idle();
    read_chk("R8 and-program", 0, 8'h10, 1);
    read_chk("R3 fast read", 1, 8'h0E, 4);
    txn('{8'h06}, 0, 0);
    txn('{8'h02, 8'h00, 8'h00, 8'h40, 8'h5A}, 0, 3);        // R7 misaligned program
    chk("R7 misaligned no busy", busy, 0);
    status_chk("R7 latch kept");
    txn('{8'h02, 8'h00, 8'h00, 8'h40, 8'h5A}, 0, 0); wait_idle();
    txn('{8'h06}, 0, 0);
    txn('{8'h01, 8'hFF}, 0, 0); wait_idle();
    status_chk("R10 write status");
    txn('{8'h06}, 0, 0);
    txn('{8'hD8, 8'h00, 8'h00, 8'h05}, 0, 0); wait_idle();
    read_chk("R9 sector erased", 0, 8'h0F, 3);
    read_chk("R9 other sector kept", 0, 8'h40, 1);
    txn('{8'h03, 8'h00, 8'h00, 8'h40}, 1, 3);
    chk("R6 cut read first byte", rx_q[0], m_mem[8'h40]);
    status_chk("R6 after cut");
    txn('{8'hAB, 8'h00, 8'h00}, 2, 0);
    chk("R13 unknown silent", oe_seen, 0);
    status_chk("R13 no effect");
    read_chk("R2 array wrap", 0, 8'hFF, 2);
    txn('{8'h06}, 0, 0);
    txn('{8'hC7}, 0, 0); wait_idle();
    read_chk("R9 bulk erase", 0, 8'h40, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule